// File: doc/BRIEF.md
# Accumulator and In-Out Register Shift/Rotate Unit

This unit carries out the shift group of a 24-bit processor. It works on two 24-bit registers, the accumulator and the in-out register, either one at a time or joined as a pair with the accumulator on the left. The unit copies both register values in when an operation starts. It moves the selected register or pair one bit position per clock and then raises a one-cycle completion pulse. The updated values of both registers are held on its outputs for the rest of the processor to write back.

The instruction fields go in unchanged. The four-bit sub-opcode is bits 21:18 of the instruction word. The four-bit count field is bits 3:0 of the instruction word, and it is held in one's-complement form. A rotate moves bits in a ring. An arithmetic shift scales the value by powers of two. It keeps the sign bit in place and fills the vacated positions with copies of the sign. In paired arithmetic mode the in-out register acts as a low-order magnitude extension of the accumulator.

Top module: `acio_shift_unit`

## Requirements
- R1: While rst_n is low, ac_out and io_out are zero and busy and done are low.
- R2: A start sampled while idle captures sub_op, cnt_field, ac_in and io_in. busy is high from the next cycle. After N steps, done is high for one cycle, exactly N+1 clock edges after the start edge. busy is low in that done cycle.
- R3: The step count N is the bitwise inverse of cnt_field, so N is 15 minus the field value. A field of 4'b1111 gives zero steps: done arrives one edge after start and both registers come back unchanged.
- R4: sub_op bit 0 selects the accumulator and bit 1 selects the in-out register. With only one of them set, that register alone moves and the other comes back unchanged. Bit 3 = 1 moves right and bit 3 = 0 moves left. Bit 2 = 0 is a rotate, in which the bit leaving one end enters at the other.
- R5: With bit 2 = 1 on a single register, bit 23 (the sign) stays fixed. Each left step shifts bits 22:0 up and puts the sign into bit 0. Each right step shifts bits 22:1 down and puts the sign into bit 22.
- R6: A rotate with both select bits set forms one 48-bit ring {ac, io}. Left: accumulator bit 23 enters in-out bit 0, and in-out bit 23 enters accumulator bit 0. Right: the reverse.
- R7: An arithmetic shift with both select bits set uses accumulator bit 23 as the only sign, and in-out bit 23 stays fixed. The magnitude is {ac[22:0], io[22:0]} (46 bits). A left step shifts it up and fills io bit 0 with the sign. A right step shifts it down and fills ac bit 22 with the sign. Accumulator bit 0 passes to in-out bit 22.
- R8: With both select bits clear, neither register changes, whatever the count. done arrives one edge after start.
- R9: A start raised while busy is ignored. It neither changes the running operation nor produces a second done.
- R10: done is never high in two consecutive cycles. While idle and without start, ac_out and io_out hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| sub_op | input | 4 | Sub-opcode field, instruction bits 21:18 |
| cnt_field | input | 4 | One's-complement count field, instruction bits 3:0 |
| ac_in | input | 24 | Accumulator value to operate on |
| io_in | input | 24 | In-out register value to operate on |
| ac_out | output | 24 | Accumulator result |
| io_out | output | 24 | In-out register result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start that arrives in the middle of a long operation. The port gives no sign that anything was dropped, so the only evidence is a missing second done pulse and an unchanged first result. The stimulus launches a fifteen-step paired shift and raises start two cycles later with different data. The scoreboard then watches for a stray done over the following idle stretch. The paired arithmetic crossing point is also hard to reach: it only shows when a negative accumulator meets an in-out value whose top bit differs from the sign. Dedicated patterns set up exactly that combination in both directions.

// File: rtl/acio_shift_pkg.sv
package acio_shift_pkg;

    localparam int DATA_W  = 24;
    localparam int COUNT_W = 4;

    typedef struct packed {
        logic right;
        logic arith;
        logic use_io;
        logic use_ac;
    } shmode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shstate_t;

endpackage

// File: rtl/acio_shift_decode.sv
module acio_shift_decode
    import acio_shift_pkg::*;
#(
    parameter int CW = COUNT_W
) (
    input  logic [3:0]    sub_op,
    input  logic [CW-1:0] cnt_field,
    output shmode_t       mode,
    output logic [CW-1:0] steps
);

    always_comb begin
        mode = shmode_t'(sub_op);
        if (mode.use_ac || mode.use_io) begin
            steps = ~cnt_field;
        end else begin
            steps = '0;
        end
    end

endmodule

// File: rtl/acio_shift_step.sv
module acio_shift_step
    import acio_shift_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  shmode_t      mode,
    input  logic [W-1:0] ac,
    input  logic [W-1:0] io,
    output logic [W-1:0] ac_nx,
    output logic [W-1:0] io_nx
);

    function automatic logic [W-1:0] single_step(input logic [W-1:0] r,
                                                 input logic right,
                                                 input logic arith);
        logic [W-1:0] res;
        case ({arith, right})
            2'b00:   res = {r[W-2:0], r[W-1]};
            2'b01:   res = {r[0], r[W-1:1]};
            2'b10:   res = {r[W-1], r[W-3:0], r[W-1]};
            default: res = {r[W-1], r[W-1], r[W-2:1]};
        endcase
        return res;
    endfunction

    logic sgn;

    always_comb begin
        sgn   = ac[W-1];
        ac_nx = ac;
        io_nx = io;
        case ({mode.use_ac, mode.use_io})
            2'b10: ac_nx = single_step(ac, mode.right, mode.arith);
            2'b01: io_nx = single_step(io, mode.right, mode.arith);
            2'b11: begin
                case ({mode.arith, mode.right})
                    2'b00: begin
                        ac_nx = {ac[W-2:0], io[W-1]};
                        io_nx = {io[W-2:0], ac[W-1]};
                    end
                    2'b01: begin
                        ac_nx = {io[0], ac[W-1:1]};
                        io_nx = {ac[0], io[W-1:1]};
                    end
                    2'b10: begin
                        ac_nx = {sgn, ac[W-3:0], io[W-2]};
                        io_nx = {io[W-1], io[W-3:0], sgn};
                    end
                    default: begin
                        ac_nx = {sgn, sgn, ac[W-2:1]};
                        io_nx = {io[W-1], ac[0], io[W-2:1]};
                    end
                endcase
            end
            default: begin
                ac_nx = ac;
                io_nx = io;
            end
        endcase
    end

endmodule

// File: rtl/acio_shift_unit.sv
module acio_shift_unit
    import acio_shift_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    sub_op,
    input  logic [CW-1:0] cnt_field,
    input  logic [W-1:0]  ac_in,
    input  logic [W-1:0]  io_in,
    output logic [W-1:0]  ac_out,
    output logic [W-1:0]  io_out,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        shstate_t      st;
        shmode_t       mode;
        logic [CW-1:0] cnt;
        logic [W-1:0]  ac;
        logic [W-1:0]  io;
        logic          done;
    } regs_t;

    regs_t         r_d, r_q;
    shmode_t       dec_mode;
    logic [CW-1:0] dec_steps;
    logic [W-1:0]  ac_nx, io_nx;

    logic m_arith, m_ac, m_io;

    acio_shift_decode #(.CW(CW)) u_dec (
        .sub_op    (sub_op),
        .cnt_field (cnt_field),
        .mode      (dec_mode),
        .steps     (dec_steps)
    );

    acio_shift_step #(.W(W)) u_step (
        .mode  (r_q.mode),
        .ac    (r_q.ac),
        .io    (r_q.io),
        .ac_nx (ac_nx),
        .io_nx (io_nx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.mode = dec_mode;
                    r_d.cnt  = dec_steps;
                    r_d.ac   = ac_in;
                    r_d.io   = io_in;
                end
            end
            default: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.ac  = ac_nx;
                    r_d.io  = io_nx;
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ac_out  = r_q.ac;
    assign io_out  = r_q.io;
    assign busy    = (r_q.st == ST_RUN);
    assign done    = r_q.done;
    assign m_arith = r_q.mode.arith;
    assign m_ac    = r_q.mode.use_ac;
    assign m_io    = r_q.mode.use_io;

endmodule

// File: rtl/acio_shift_unit_chk.sv
module acio_shift_unit_chk #(
    parameter int W  = 24,
    parameter int CW = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] ac_out,
    input logic [W-1:0] io_out,
    input logic         m_arith,
    input logic         m_ac,
    input logic         m_io
);

    localparam logic [CW+1:0] LIM = (CW+2)'(1 << CW);

    logic [CW+1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ac_out == '0 && io_out == '0 && !busy && !done));

    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < LIM));

    p_ac_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && m_io && !m_ac) |=> $stable(ac_out));

    p_io_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && m_ac && !m_io) |=> $stable(io_out));

    p_ac_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && m_arith && m_ac) |=> $stable(ac_out[W-1]));

    p_ring_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !m_arith && m_ac && m_io) |=>
            ($countones({ac_out, io_out}) == $countones($past({ac_out, io_out}))));

    p_io_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && m_arith && m_ac && m_io) |=> $stable(io_out[W-1]));

    p_no_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !m_ac && !m_io) |=> ($stable(ac_out) && $stable(io_out) && done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ac_out) && $stable(io_out)));

endmodule

bind acio_shift_unit acio_shift_unit_chk #(.W(W), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ac_out  (ac_out),
    .io_out  (io_out),
    .m_arith (m_arith),
    .m_ac    (m_ac),
    .m_io    (m_io)
);

// File: tb/acio_shift_unit_test.sv
module acio_shift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  sub_op = '0;
    logic [3:0]  cnt_field = '0;
    logic [23:0] ac_in = '0;
    logic [23:0] io_in = '0;
    logic [23:0] ac_out, io_out;
    logic        busy, done;

    int n_check = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int n_push  = 0;
    int n_done  = 0;

    typedef struct {
        logic [23:0] ac;
        logic [23:0] io;
        int          due;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    acio_shift_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
        .cnt_field(cnt_field), .ac_in(ac_in), .io_in(io_in),
        .ac_out(ac_out), .io_out(io_out), .busy(busy), .done(done)
    );

    function automatic longint unsigned rot(input longint unsigned x, input int w,
                                            input int n, input logic right);
        longint unsigned mask = (64'd1 << w) - 1;
        if (n == 0) return x;
        if (right) return ((x >> n) | (x << (w - n))) & mask;
        return ((x << n) | (x >> (w - n))) & mask;
    endfunction

    function automatic longint unsigned ash(input longint unsigned m, input int mw,
                                            input int n, input logic s, input logic right);
        longint unsigned mask = (64'd1 << mw) - 1;
        longint unsigned ones = (64'd1 << n) - 1;
        if (right) return ((m >> n) | (s ? (ones << (mw - n)) : 64'd0)) & mask;
        return ((m << n) | (s ? ones : 64'd0)) & mask;
    endfunction

    function automatic logic [47:0] model(input logic [3:0] sub, input int n,
                                          input logic [23:0] a, input logic [23:0] b);
        logic right = sub[3];
        logic ar    = sub[2];
        logic uio   = sub[1];
        logic uac   = sub[0];
        longint unsigned r;
        logic [23:0] ra = a;
        logic [23:0] rb = b;
        if (uac && uio) begin
            if (!ar) begin
                r  = rot({16'd0, a, b}, 48, n, right);
                ra = r[47:24];
                rb = r[23:0];
            end else begin
                r  = ash({18'd0, a[22:0], b[22:0]}, 46, n, a[23], right);
                ra = {a[23], r[45:23]};
                rb = {b[23], r[22:0]};
            end
        end else if (uac) begin
            if (!ar) ra = 24'(rot({40'd0, a}, 24, n, right));
            else begin
                r  = ash({41'd0, a[22:0]}, 23, n, a[23], right);
                ra = {a[23], r[22:0]};
            end
        end else if (uio) begin
            if (!ar) rb = 24'(rot({40'd0, b}, 24, n, right));
            else begin
                r  = ash({41'd0, b[22:0]}, 23, n, b[23], right);
                rb = {b[23], r[22:0]};
            end
        end
        return {ra, rb};
    endfunction

    task automatic launch(input logic [3:0] sub, input int field,
                          input logic [23:0] a, input logic [23:0] b, input string tag);
        exp_t e;
        int   n;
        logic [47:0] res;
        n   = (sub[1] || sub[0]) ? (15 - field) : 0;
        res = model(sub, n, a, b);
        @(negedge clk);
        sub_op    = sub;
        cnt_field = 4'(field);
        ac_in     = a;
        io_in     = b;
        start     = 1'b1;
        e.ac  = res[47:24];
        e.io  = res[23:0];
        e.due = cyc + n + 2;
        e.tag = tag;
        exp_q.push_back(e);
        n_push++;
        @(negedge clk);
        start = 1'b0;
        ac_in = ~a;
        io_in = ~b;
        sub_op = ~sub;
        cnt_field = ~cnt_field;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_op(input logic [3:0] sub, input int field,
                          input logic [23:0] a, input logic [23:0] b, input string tag);
        launch(sub, field, a, b, tag);
        wait_done();
    endtask

    task automatic check(input bit ok, input string msg);
        n_check++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            n_done++;
            n_check++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected done, ac=%h io=%h expected none", ac_out, io_out);
            end else begin
                e = exp_q.pop_front();
                if (ac_out !== e.ac || io_out !== e.io || cyc != e.due) begin
                    n_fail++;
                    $display("FAIL %s: ac=%h io=%h cyc=%0d expected ac=%h io=%h cyc=%0d",
                             e.tag, ac_out, io_out, cyc, e.ac, e.io, e.due);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_check++;
        n_fail++;
        $display("FAIL R2: watchdog expired, done never arrived");
        $display("End of test - %0d assertions evaluated, %0d failures", n_check, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] ha, hb;
        ac_in = 24'hABCDEF;
        io_in = 24'h123456;
        repeat (3) @(negedge clk);
        check(ac_out == '0 && io_out == '0 && !busy && !done,
              $sformatf("R1: reset ac=%h io=%h busy=%b done=%b expected 0", ac_out, io_out, busy, done));
        rst_n = 1'b1;

        // R2: busy right after the start edge, no early done
        launch(4'b1001, 4'b1100, 24'h800001, 24'h0F0F0F, "R2 R4 rar n3");
        check(busy && !done, $sformatf("R2: after start busy=%b done=%b expected 1 0", busy, done));
        wait_done();

        // R4 single-register rotates
        run_op(4'b0001, 8,  24'hC00003, 24'h5A5A5A, "R4 ral n7");
        run_op(4'b1010, 4,  24'h111111, 24'h000081, "R4 rir n11");
        run_op(4'b0010, 0,  24'hFFFF00, 24'h900001, "R4 ril n15");

        // R5 single-register arithmetic shifts
        run_op(4'b1101, 11, 24'h800010, 24'h333333, "R5 sar neg n4");
        run_op(4'b0101, 10, 24'h801234, 24'h444444, "R5 sal neg n5");
        run_op(4'b0101, 12, 24'h412345, 24'h555555, "R5 sal pos n3");
        run_op(4'b1110, 9,  24'h666666, 24'hC00100, "R5 sir neg n6");
        run_op(4'b0110, 13, 24'h777777, 24'h000C01, "R5 sil pos n2");

        // R6 paired rotates
        run_op(4'b0011, 0, 24'h800001, 24'h400003, "R6 rcl n15");
        run_op(4'b1011, 7, 24'h123457, 24'hFEDCB9, "R6 rcr n8");

        // R7 paired arithmetic shifts, crossing bit vs in-out sign position
        run_op(4'b0111, 10, 24'h9ABCDE, 24'h412345, "R7 scl neg n5");
        run_op(4'b1111, 6,  24'hC00003, 24'h000000, "R7 scr neg n9");
        run_op(4'b1111, 11, 24'h000011, 24'h800000, "R7 scr pos n4");
        run_op(4'b0111, 2,  24'h000001, 24'hBFFFFF, "R7 scl pos n13");

        // R3 all-ones field: zero steps
        run_op(4'b1101, 15, 24'h876543, 24'h234567, "R3 zero steps");
        run_op(4'b0011, 14, 24'h800000, 24'h000001, "R3 one step");

        // R8 no register selected
        run_op(4'b1100, 0, 24'hDEAD12, 24'hBEEF34, "R8 no select n15");
        run_op(4'b0000, 5, 24'h00FF00, 24'hFF00FF, "R8 no select n10");

        // R9 start while busy is ignored
        launch(4'b1111, 0, 24'hF0F0F1, 24'h0E0E0E, "R9 long scr");
        @(negedge clk);
        sub_op = 4'b0001; cnt_field = 4'b1110; ac_in = 24'h000001; io_in = 24'h000002;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        check(n_done == n_push,
              $sformatf("R9: done count=%0d expected %0d", n_done, n_push));

        // R10 outputs hold while idle, done single pulse
        run_op(4'b0001, 12, 24'h00000F, 24'h0000F0, "R10 ral n3");
        @(negedge clk);
        check(!done, $sformatf("R10: done=%b one cycle after pulse expected 0", done));
        ha = ac_out;
        hb = io_out;
        repeat (4) @(negedge clk);
        check(ac_out == ha && io_out == hb,
              $sformatf("R10: idle ac=%h io=%h expected ac=%h io=%h", ac_out, io_out, ha, hb));
        check(exp_q.size() == 0,
              $sformatf("R2: pending results=%0d expected 0", exp_q.size()));

        $display("End of test - %0d assertions evaluated, %0d failures", n_check, n_fail);
        $finish;
    end

endmodule